// File: doc/BRIEF.md
# Shared Counter with Per-Processor Compare Timers

This block holds one free-running counter that every processor in a cluster shares, and gives each processor its own compare register and its own timer-pending flag. Software reads the counter as two 32-bit words. A stable value is taken by reading the upper word, then the lower word, then the upper word again, and retrying when the two upper reads disagree. Each processor programs its compare value as two 32-bit words. When the counter reaches that value, the processor's pending flag sets and stays set until that processor's compare register is written again.

All accesses go through one 32-bit register port. A sideband input carries the index of the processor that issues each access. A local window reaches the issuing processor's own compare register and pending flag. An indirect window reaches any processor's compare register and pending flag: the issuer first writes the target index into its own selector register. A read-only configuration word reports the processor count and the counter width so that software can size itself.

Top module: `shared_timer_cmp`

## Requirements
- R1: Reset clears the counter to zero. The counter adds one on every clock where `cntEnable` is high, holds its value when `cntEnable` is low, and wraps to zero after reaching the all-ones value of `CNT_BITS` bits.
- R2: Reading word 1 returns counter bits 31..0. Reading word 2 returns the counter bits above bit 31, right-aligned. Bits beyond `CNT_BITS` read as zero.
- R3: Word 0 is read-only configuration. Bits 3..0 hold `NUM_CPU`-1, bits 11..8 hold (`CNT_BITS`-32)/4, and all other bits read zero.
- R4: Word 4 (low half) and word 5 (high half) read and write the issuing processor's compare value. A write to word 5 keeps only data bits `CNT_BITS`-33..0, and unused upper bits read zero. The compare value resets to all ones, and each write takes effect on the next clock.
- R5: Bit 0 of word 6 and `timerPend[i]` show processor i's timer flag. The flag sets on the clock after the counter equals that processor's compare value. It stays set until either half of that processor's compare is written, and it reads 0 on the next cycle after such a write. When a write and a match happen in the same cycle, the write wins.
- R6: Word 3 is the issuing processor's selector. It is `CPU_W` bits wide and resets to 0. Words 8, 9 and 10 act like words 4, 5 and 6, but on the processor named by the issuer's selector.
- R7: When the selector names an index of `NUM_CPU` or above, writes through words 8 and 9 change nothing, and reads of words 8, 9 and 10 return zero.
- R8: Addresses 7 and 11 to 15 read zero, and writes to them change no state.
- R9: Writes to the read-only words 0, 1, 2, 6 and 10 change neither the counter, the compare values nor any pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cntEnable | input | 1 | Counter advance enable |
| regWrEn | input | 1 | Write strobe for the register port |
| regAddr | input | 4 | Word address |
| regWrData | input | 32 | Write data |
| regCpu | input | CPU_W | Index of the processor issuing the access |
| regRdData | output | 32 | Read data for `regAddr`, combinational |
| timerPend | output | NUM_CPU | Timer-pending flag of each processor |

## Verification
The bench builds the block with three processors and a 40-bit counter. With three processors the 2-bit selector can hold the value 3, which names no processor, so the ignored-write and zero-read behaviour of the indirect window can be reached. With 40 bits, the high-half masking on compare writes is visible, and so is the configuration encoding of a width that is neither 32 nor 64. Every issuer is swept against every target through both windows. The pending flag is polled cycle by cycle across a match, and each poll is checked against an arithmetic model of the counter.

// File: rtl/shared_timer_cmp_pkg.sv
package shared_timer_cmp_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CONFIG   = 4'd0;
  localparam logic [ADDR_W-1:0] A_CNT_LO   = 4'd1;
  localparam logic [ADDR_W-1:0] A_CNT_HI   = 4'd2;
  localparam logic [ADDR_W-1:0] A_SELECT   = 4'd3;
  localparam logic [ADDR_W-1:0] A_OWN_LO   = 4'd4;
  localparam logic [ADDR_W-1:0] A_OWN_HI   = 4'd5;
  localparam logic [ADDR_W-1:0] A_OWN_PEND = 4'd6;
  localparam logic [ADDR_W-1:0] A_IND_LO   = 4'd8;
  localparam logic [ADDR_W-1:0] A_IND_HI   = 4'd9;
  localparam logic [ADDR_W-1:0] A_IND_PEND = 4'd10;

  typedef enum logic [2:0] {
    RD_ZERO, RD_CFG, RD_CNT_LO, RD_CNT_HI, RD_SEL, RD_CMP_LO, RD_CMP_HI, RD_PEND
  } rd_sel_e;

  typedef struct packed {
    logic    wrCmpLo;
    logic    wrCmpHi;
    logic    wrSel;
    logic    useOther;
    rd_sel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/shared_timer_cmp_ctrl.sv
module shared_timer_cmp_ctrl
  import shared_timer_cmp_pkg::*;
(
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output strobe_t           strobe
);
  always_comb begin
    strobe = '0;
    strobe.rdSel = RD_ZERO;
    unique case (regAddr)
      A_CONFIG:   strobe.rdSel = RD_CFG;
      A_CNT_LO:   strobe.rdSel = RD_CNT_LO;
      A_CNT_HI:   strobe.rdSel = RD_CNT_HI;
      A_SELECT: begin
        strobe.rdSel = RD_SEL;
        strobe.wrSel = regWrEn;
      end
      A_OWN_LO, A_IND_LO: begin
        strobe.rdSel    = RD_CMP_LO;
        strobe.wrCmpLo  = regWrEn;
        strobe.useOther = (regAddr == A_IND_LO);
      end
      A_OWN_HI, A_IND_HI: begin
        strobe.rdSel    = RD_CMP_HI;
        strobe.wrCmpHi  = regWrEn;
        strobe.useOther = (regAddr == A_IND_HI);
      end
      A_OWN_PEND, A_IND_PEND: begin
        strobe.rdSel    = RD_PEND;
        strobe.useOther = (regAddr == A_IND_PEND);
      end
      default: strobe.rdSel = RD_ZERO;
    endcase
  end
endmodule

// File: rtl/shared_timer_cmp_dp.sv
module shared_timer_cmp_dp
  import shared_timer_cmp_pkg::*;
#(
  parameter int NUM_CPU  = 4,
  parameter int CNT_BITS = 64,
  parameter int CPU_W    = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cntEnable,
  input  strobe_t             strobe,
  input  logic [CPU_W-1:0]    cpuId,
  input  logic [31:0]         wrData,
  output logic [31:0]         rdData,
  output logic [CNT_BITS-1:0] cntVal,
  output logic [NUM_CPU-1:0]  timerPend
);
  localparam int HI_BITS     = CNT_BITS - 32;
  localparam int WIDTH_FIELD = (CNT_BITS - 32) / 4;

  logic [CPU_W-1:0]    selReg [NUM_CPU];
  logic [CNT_BITS-1:0] cmpReg [NUM_CPU];
  logic [NUM_CPU-1:0]  pendReg;
  logic [CPU_W-1:0]    ownSel, tgtIdx;
  logic                ownValid, tgtValid;
  logic [NUM_CPU-1:0]  ownHit, tgtHit;
  logic [CNT_BITS-1:0] tgtCmp;
  logic                tgtPend;
  logic [63:0]         cntExt, cmpExt;

  // shared counter
  always_ff @(posedge clk) begin
    if (!rstN)          cntVal <= '0;
    else if (cntEnable) cntVal <= cntVal + 1'b1;
  end

  // resolve the issuer and the target of the access
  always_comb begin
    ownSel   = '0;
    ownValid = 1'b0;
    for (int i = 0; i < NUM_CPU; i++) begin
      ownHit[i] = (cpuId == CPU_W'(i));
      if (ownHit[i]) begin
        ownSel   = selReg[i];
        ownValid = 1'b1;
      end
    end
    tgtIdx   = strobe.useOther ? ownSel : cpuId;
    tgtValid = ownValid && ({1'b0, tgtIdx} < (CPU_W + 1)'(NUM_CPU));
    tgtCmp   = '0;
    tgtPend  = 1'b0;
    for (int i = 0; i < NUM_CPU; i++) begin
      tgtHit[i] = tgtValid && (tgtIdx == CPU_W'(i));
      if (tgtHit[i]) begin
        tgtCmp  = cmpReg[i];
        tgtPend = pendReg[i];
      end
    end
  end

  // per-processor selector, compare and pending state
  for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu
    logic cmpWrite;
    assign cmpWrite = tgtHit[i] && (strobe.wrCmpLo || strobe.wrCmpHi);

    always_ff @(posedge clk) begin
      if (!rstN)                            selReg[i] <= '0;
      else if (strobe.wrSel && ownHit[i])   selReg[i] <= wrData[CPU_W-1:0];
    end

    always_ff @(posedge clk) begin
      if (!rstN)                            cmpReg[i][31:0] <= '1;
      else if (strobe.wrCmpLo && tgtHit[i]) cmpReg[i][31:0] <= wrData;
    end

    if (HI_BITS > 0) begin : g_hi
      always_ff @(posedge clk) begin
        if (!rstN)                            cmpReg[i][CNT_BITS-1:32] <= '1;
        else if (strobe.wrCmpHi && tgtHit[i]) cmpReg[i][CNT_BITS-1:32] <= wrData[HI_BITS-1:0];
      end
    end

    // a compare write beats a match in the same cycle
    always_ff @(posedge clk) begin
      if (!rstN)                      pendReg[i] <= 1'b0;
      else if (cmpWrite)              pendReg[i] <= 1'b0;
      else if (cntVal == cmpReg[i])   pendReg[i] <= 1'b1;
    end
  end

  assign timerPend = pendReg;
  assign cntExt    = 64'(cntVal);
  assign cmpExt    = 64'(tgtCmp);

  always_comb begin
    unique case (strobe.rdSel)
      RD_CFG:    rdData = {20'd0, 4'(WIDTH_FIELD), 4'd0, 4'(NUM_CPU - 1)};
      RD_CNT_LO: rdData = cntExt[31:0];
      RD_CNT_HI: rdData = cntExt[63:32];
      RD_SEL:    rdData = 32'(ownSel);
      RD_CMP_LO: rdData = cmpExt[31:0];
      RD_CMP_HI: rdData = cmpExt[63:32];
      RD_PEND:   rdData = {31'd0, tgtPend};
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/shared_timer_cmp.sv
module shared_timer_cmp
  import shared_timer_cmp_pkg::*;
#(
  parameter int NUM_CPU  = 4,
  parameter int CNT_BITS = 64,
  localparam int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cntEnable,
  input  logic               regWrEn,
  input  logic [3:0]         regAddr,
  input  logic [31:0]        regWrData,
  input  logic [CPU_W-1:0]   regCpu,
  output logic [31:0]        regRdData,
  output logic [NUM_CPU-1:0] timerPend
);
  strobe_t             strobe;
  logic [CNT_BITS-1:0] cntVal;

  shared_timer_cmp_ctrl ctrl_i (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strobe  (strobe)
  );

  shared_timer_cmp_dp #(
    .NUM_CPU  (NUM_CPU),
    .CNT_BITS (CNT_BITS),
    .CPU_W    (CPU_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .cntEnable (cntEnable),
    .strobe    (strobe),
    .cpuId     (regCpu),
    .wrData    (regWrData),
    .rdData    (regRdData),
    .cntVal    (cntVal),
    .timerPend (timerPend)
  );
endmodule

// File: rtl/shared_timer_cmp_chk.sv
module shared_timer_cmp_chk #(
  parameter int NUM_CPU  = 4,
  parameter int CNT_BITS = 64
) (
  input logic                clk,
  input logic                rstN,
  input logic                cntEnable,
  input logic                regWrEn,
  input logic [CNT_BITS-1:0] cntVal,
  input logic [NUM_CPU-1:0]  timerPend
);
  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    cntEnable |=> cntVal == CNT_BITS'($past(cntVal) + 1'b1));

  assert_count_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    !cntEnable |=> $stable(cntVal));

  for (genvar i = 0; i < NUM_CPU; i++) begin : g_pend
    assert_pend_clear_by_write_R5: assert property (@(posedge clk) disable iff (!rstN)
      $fell(timerPend[i]) |-> $past(regWrEn));

    assert_pend_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
      (timerPend[i] && !regWrEn) |=> timerPend[i]);
  end
endmodule

bind shared_timer_cmp shared_timer_cmp_chk #(
  .NUM_CPU  (NUM_CPU),
  .CNT_BITS (CNT_BITS)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .cntEnable (cntEnable),
  .regWrEn   (regWrEn),
  .cntVal    (cntVal),
  .timerPend (timerPend)
);

// File: tb/shared_timer_cmp_tb_top.sv
module shared_timer_cmp_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCPU = 3;
  localparam int CBITS = 40;
  localparam int CW = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cntEnable = 1'b1;
  logic regWrEn = 1'b0;
  logic [3:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [CW-1:0] regCpu = '0;
  logic [31:0] regRdData;
  logic [NCPU-1:0] timerPend;

  int checks = 0;
  int errors = 0;
  logic [CBITS-1:0] model = '0;
  logic [31:0] cmpLoModel [NCPU];

  always #(CLK_PERIOD/2) clk = ~clk;

  // arithmetic model of the counter (R1)
  always @(posedge clk) begin
    if (!rstN) model <= '0;
    else if (cntEnable) model <= model + 1'b1;
  end

  shared_timer_cmp #(.NUM_CPU(NCPU), .CNT_BITS(CBITS)) dut_i (
    .clk(clk), .rstN(rstN), .cntEnable(cntEnable), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regCpu(regCpu),
    .regRdData(regRdData), .timerPend(timerPend)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int cpu, input int addr, input logic [31:0] data);
    @(negedge clk);
    regCpu = CW'(cpu); regAddr = 4'(addr); regWrData = data; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input int cpu, input int addr, output logic [31:0] data);
    @(negedge clk);
    regCpu = CW'(cpu); regAddr = 4'(addr);
    #1 data = regRdData;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [39:0] c;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // reset state
    rd(0, 1, v); chk("R1 count after reset", v, model[31:0]);
    for (int i = 0; i < NCPU; i++) begin
      rd(i, 4, v); chk("R4 reset cmp lo", v, 32'hFFFF_FFFF);
      rd(i, 5, v); chk("R4 reset cmp hi", v, 32'h0000_00FF);
      rd(i, 3, v); chk("R6 reset selector", v, 0);
      rd(i, 6, v); chk("R5 reset pend", v, 0);
    end
    chk("R5 reset timerPend", 32'(timerPend), 0);

    // configuration word
    rd(2, 0, v); chk("R3 config", v, 32'h0000_0202);

    // counter reads and enable
    for (int k = 0; k < 6; k++) begin
      rd(k % NCPU, 1, v); chk("R2 count lo", v, model[31:0]);
      rd(k % NCPU, 2, v); chk("R2 count hi", v, 32'(model[39:32]));
    end
    @(negedge clk); cntEnable = 1'b0;
    rd(0, 1, v);
    c = 40'(v);
    for (int k = 0; k < 5; k++) begin
      rd(1, 1, v); chk("R1 hold when disabled", v, c[31:0]);
    end
    @(negedge clk); cntEnable = 1'b1;
    repeat (3) @(negedge clk);
    rd(0, 1, v); chk("R1 counting resumed", v, model[31:0]);

    // local compare windows, high half masking
    for (int i = 0; i < NCPU; i++) begin
      cmpLoModel[i] = 32'h1357_0000 + 32'(i * 17);
      wr(i, 5, 32'hFFFF_FFA0 + 32'(i));
      wr(i, 4, cmpLoModel[i]);
    end
    for (int i = 0; i < NCPU; i++) begin
      rd(i, 4, v); chk("R4 local cmp lo", v, cmpLoModel[i]);
      rd(i, 5, v); chk("R4 local cmp hi masked", v, 32'h0000_00A0 + 32'(i));
    end

    // indirect window: every issuer against every target
    for (int s = 0; s < NCPU; s++) begin
      for (int t = 0; t < NCPU; t++) begin
        wr(s, 3, 32'(t));
        rd(s, 3, v); chk("R6 selector readback", v, 32'(t));
        rd(s, 8, v); chk("R6 other cmp lo", v, cmpLoModel[t]);
        rd(s, 9, v); chk("R6 other cmp hi", v, 32'h0000_00A0 + 32'(t));
      end
    end
    wr(0, 3, 2);
    cmpLoModel[2] = 32'hCAFE_0002;
    wr(0, 8, cmpLoModel[2]);
    rd(2, 4, v); chk("R6 other write lands on target", v, cmpLoModel[2]);
    rd(0, 4, v); chk("R6 issuer cmp untouched", v, cmpLoModel[0]);

    // selector naming no processor
    wr(1, 3, 3);
    wr(1, 8, 32'h0BAD_0BAD);
    wr(1, 9, 32'h0000_0011);
    for (int i = 0; i < NCPU; i++) begin
      rd(i, 4, v); chk("R7 invalid target write ignored lo", v, cmpLoModel[i]);
      rd(i, 5, v); chk("R7 invalid target write ignored hi", v, 32'h0000_00A0 + 32'(i));
    end
    rd(1, 8, v);  chk("R7 invalid target lo reads 0", v, 0);
    rd(1, 9, v);  chk("R7 invalid target hi reads 0", v, 0);
    rd(1, 10, v); chk("R7 invalid target pend reads 0", v, 0);

    // pending flag across a match, processor 1
    c = model + 40'd20;
    wr(1, 5, 32'(c[39:32]));
    wr(1, 4, c[31:0]);
    for (int k = 0; k < 30; k++) begin
      rd(1, 6, v);
      chk("R5 local pend vs match", v, (model > c) ? 32'd1 : 32'd0);
      chk("R5 timerPend vector", 32'(timerPend), (model > c) ? 32'd2 : 32'd0);
    end

    // read-only and unmapped writes leave state alone
    wr(1, 6, 0);
    wr(1, 10, 0);
    wr(1, 0, 32'hFFFF_FFFF);
    wr(1, 1, 0);
    wr(1, 2, 0);
    wr(1, 7, 32'h1234_5678);
    for (int a = 11; a < 16; a++) wr(1, a, 32'h5555_5555);
    rd(1, 6, v);  chk("R9 pend survives read-only writes", v, 1);
    rd(0, 1, v);  chk("R9 count unaffected", v, model[31:0]);
    rd(1, 4, v);  chk("R9 cmp unaffected", v, c[31:0]);
    rd(0, 4, v);  chk("R8 cmp of cpu0 unaffected", v, cmpLoModel[0]);
    rd(0, 7, v);  chk("R8 unmapped 7 reads 0", v, 0);
    for (int a = 11; a < 16; a++) begin
      rd(0, a, v); chk("R8 unmapped reads 0", v, 0);
    end
    rd(0, 3, v); chk("R8 selector unaffected", v, 2);

    // clearing by compare writes, local low and indirect high
    wr(1, 4, c[31:0]);
    rd(1, 6, v); chk("R5 cleared by lo write", v, 0);
    c = model + 40'd8;
    wr(1, 5, 32'(c[39:32]));
    wr(1, 4, c[31:0]);
    repeat (14) @(negedge clk);
    rd(1, 6, v); chk("R5 set again", v, 1);
    wr(2, 3, 1);
    rd(2, 10, v); chk("R6 other pend read", v, 1);
    wr(2, 9, 32'(c[39:32]));
    rd(2, 10, v); chk("R5 cleared by other hi write", v, 0);
    chk("R5 vector after clear", 32'(timerPend), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule